// File: doc/BRIEF.md
# Scan-Programmed Two-Cell Lookup Fabric

This block is a very small reconfigurable logic fabric. It has two logic cells, each a 3-input, 2-output lookup table held in an 8-entry by 2-bit store. A 2x2 crosspoint switch joins them. The first cell reads three external inputs. Its two outputs feed the switch. The switch outputs drive two inputs of the second cell. The third input of the second cell is a separate external pin. The outputs of the second cell are the outputs of the block.

All 36 configuration bits sit in flip-flops: 16 per lookup table and 4 in the switch. While the configuration-enable pin is high, these flip-flops form a single serial shift chain fed from a serial data pin, and one bit moves in on each clock. While the pin is low, the configuration holds, and the fabric behaves as combinational logic from its four data inputs to its two outputs.

Top module: `lut_fabric`

## Requirements
- R1: An active-low reset clears all 36 configuration flip-flops to 0, so both outputs read 0 for every input value until the fabric is programmed.
- R2: On each rising clock edge with `cfg_en` high, chain position 0 takes `cfg_din`, and every position p>0 takes the old value of position p-1.
- R3: On each rising clock edge with `cfg_en` low, no configuration bit changes, whatever `cfg_din` does.
- R4: Chain positions 0..15 hold the first cell's table, where position 2*e+b is bit b of entry e. Positions 16..19 hold switch bits 0..3. Positions 20..35 hold the second cell's table, using the same 2*e+b layout.
- R5: Each cell addresses its table with {in2,in1,in0}. Bit 0 of the addressed entry drives cell output 0, and bit 1 drives cell output 1. The first cell's in0/in1/in2 are `xin[0]`/`xin[1]`/`xin[2]`.
- R6: Switch bit k = 2*o + i connects switch input i (first cell output i) to switch output o. Each switch output is the OR of its connected inputs, and a switch output with no connection reads 0.
- R7: Switch output 0 drives the second cell's in0, switch output 1 drives its in1, and `yin` drives its in2. `zout[1:0]` are the second cell's outputs 1 and 0.
- R8: Holding `cfg_en` high for exactly 36 clocks, and presenting the bit meant for position 35 first and the bit for position 0 last, loads a complete image.
- R9: With `cfg_en` low, `zout` settles within the same cycle as any change on `xin` or `yin`, with no clock edge between them.
- R10: With the image that computes a 2-bit sum, `zout` equals bits [2:1] of {a1,a0}+{b1,b0} for all 16 operand pairs, where `xin`={a1,b0,a0} and `yin`=b1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset of all configuration bits |
| cfg_en | input | 1 | High: shift the chain; low: hold it |
| cfg_din | input | 1 | Serial configuration bit entering chain position 0 |
| xin | input | 3 | First cell inputs {in2,in1,in0} |
| yin | input | 1 | Second cell in2 |
| zout | output | 2 | Second cell outputs {out1,out0} |

## Verification
The ports cannot show the configuration directly. Each stored bit is visible only when a lookup address and a switch route expose it. The hardest case is a wrong chain order or a wrong switch bit mapping, because such a fault can hide behind a symmetric image. To reach it, the bench loads every one of the 16 switch patterns under asymmetric table contents and sweeps all 16 input vectors for each. It adds several pseudo-random images, one extra single-bit shift applied after a full load, and a hold phase where `cfg_din` toggles while `cfg_en` stays low.

// File: rtl/lut_fabric.sv
module lut_fabric #(
  parameter int IN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic [IN_W-1:0] xin,
  input  logic            yin,
  output logic [1:0]      zout
);
  localparam int LUT_BITS = 2 * (1 << IN_W);
  localparam int SW_BITS  = 4;
  localparam int CHAIN    = 2 * LUT_BITS + SW_BITS;
  localparam int SW_BASE  = LUT_BITS;
  localparam int B_BASE   = LUT_BITS + SW_BITS;

  logic [CHAIN-1:0]    cfg;
  logic [LUT_BITS-1:0] lut_a, lut_b;
  logic [SW_BITS-1:0]  sw;
  logic [1:0]          a_out, sw_out;
  logic [IN_W-1:0]     b_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= {cfg[CHAIN-2:0], cfg_din};

  assign lut_a = cfg[LUT_BITS-1:0];
  assign sw    = cfg[SW_BASE +: SW_BITS];
  assign lut_b = cfg[B_BASE +: LUT_BITS];

  assign a_out = lut_a[{xin, 1'b0} +: 2];

  for (genvar o = 0; o < 2; o++) begin : g_xbar
    assign sw_out[o] = |(sw[2*o +: 2] & a_out);
  end

  assign b_addr = {yin, sw_out};
  assign zout   = lut_b[{b_addr, 1'b0} +: 2];
endmodule

module lut_fabric_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        cfg_din,
  input logic [2:0]  xin,
  input logic        yin,
  input logic [1:0]  zout,
  input logic [35:0] cfg
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg == {$past(cfg[34:0]), $past(cfg_din)}));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg));

  p_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |-> (zout == 2'b00));

  p_noroute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[19:16] == 4'b0000) |-> (zout == cfg[6'd20 + {2'b00, yin, 3'b000} +: 2]));

  p_comb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(xin) && $stable(yin) && $stable(cfg)) |-> $stable(zout));
endmodule

bind lut_fabric lut_fabric_chk u_chk (.*);

// File: tb/sim_lut_fabric.sv
module sim_lut_fabric;
  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_din = 0, yin = 0;
  logic [2:0] xin = 0;
  logic [1:0] zout;
  int checks = 0, fails = 0;
  bit done = 0;

  lut_fabric u0 (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
                 .xin(xin), .yin(yin), .zout(zout));

  always #2 clk = ~clk;

  function automatic logic [1:0] model(logic [35:0] img, logic [2:0] x, logic y);
    logic [1:0] a, m;
    logic [2:0] b;
    a = {img[2*x+1], img[2*x]};
    m[0] = (img[16] & a[0]) | (img[17] & a[1]);
    m[1] = (img[18] & a[0]) | (img[19] & a[1]);
    b = {y, m};
    return {img[20+2*b+1], img[20+2*b]};
  endfunction

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: zout=%b expected %b (xin=%b yin=%b)", req, got, exp, xin, yin);
    end
  endtask

  task automatic load(logic [35:0] img);
    for (int i = 35; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1; cfg_din = img[i];
    end
    @(negedge clk); cfg_en = 0; cfg_din = 0;
  endtask

  task automatic sweep(string req, logic [35:0] img);
    for (int v = 0; v < 16; v++) begin
      xin = v[2:0]; yin = v[3];
      #1; chk(req, zout, model(img, xin, yin));
    end
  endtask

  function automatic logic [35:0] adder_img();
    logic [35:0] img = '0;
    for (int e = 0; e < 8; e++) begin
      logic a0, b0, a1, c0, u, v;
      a0 = e[0]; b0 = e[1]; a1 = e[2];
      c0 = a0 & b0; u = a1 ^ c0; v = a1 & c0;
      img[2*e] = u; img[2*e+1] = v;
    end
    img[16] = 1; img[19] = 1;
    for (int e = 0; e < 8; e++) begin
      logic u, v, b1;
      u = e[0]; v = e[1]; b1 = e[2];
      img[20+2*e] = u ^ b1; img[20+2*e+1] = v | (u & b1);
    end
    return img;
  endfunction

  initial begin
    logic [35:0] img;
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 16; v++) begin
      xin = v[2:0]; yin = v[3]; #1; chk("R1 reset", zout, 2'b00);
    end
    rst_n = 1;

    img = adder_img();
    load(img);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        logic [2:0] s;
        s = 3'(a) + 3'(b);
        xin = {a[1], b[0], a[0]}; yin = b[1];
        #1; chk("R10 R8 adder", zout, s[2:1]);
      end

    for (int s = 0; s < 16; s++) begin
      img = {16'hC3A5, 4'(s), 16'h6E19};
      load(img);
      sweep("R6 R7 R5 switch", img);
    end

    for (int e = 0; e < 8; e++) begin
      img = '0; img[2*e] = 1; img[16] = 1; img[20+2] = 1; img[20+1] = 1;
      load(img);
      sweep("R4 R5 order", img);
    end

    for (int r = 0; r < 6; r++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      img[31:0] = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      img[35:32] = seed[31:28];
      load(img);
      sweep("R8 random", img);
    end

    for (int c = 0; c < 10; c++) begin
      @(negedge clk); cfg_din = ~cfg_din;
    end
    sweep("R3 hold", img);

    @(negedge clk); cfg_en = 1; cfg_din = 1;
    @(negedge clk); cfg_en = 0; cfg_din = 0;
    img = {img[34:0], 1'b1};
    sweep("R2 shift", img);

    img = 36'h9_5A3C_F0E1;
    load(img);
    xin = 3'b101; yin = 0; #1; chk("R9 comb", zout, model(img, xin, yin));
    xin = 3'b010; yin = 1; #1; chk("R9 comb", zout, model(img, xin, yin));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule